// File: doc/BRIEF.md
# Page-Filtered Event Counter Unit

This block watches a stream of bus-transaction records and counts the events that software has defined. Each record carries a command, a source node, a destination node, a page number, an offset within the page, a direction flag and a request/response flag. Classification happens in two steps. First, the page number and destination node are looked up in a small programmable page table. Then the index of the page table entry that hit is compared against every entry of an event station. Each station entry names a page table slot, an inclusive offset window and a transaction type.

Every station entry owns a counter. The counter advances by one for each accepted record that matches the entry, but only while software has the entry armed. When a counter reaches its all-ones value, the block emits the event index and that full value on a valid/ready spill stream, and the counter restarts from zero. An external ring buffer can collect the spilled values. While a spill is waiting, the record input is held off, so no count is ever lost. Software programs the page table, the event descriptors and the arm state through one write port. It reads any counter through a combinational read port.

Top module: `pfec_unit`

## Requirements
- R1: After reset, `rec_ready` is 1, `spill_valid` is 0, every counter reads 0, every page entry is invalid and every event is disarmed.
- R2: A page entry is written with `cfg_sel`=0 and `cfg_data` = {valid[26], node[25:20], page[19:0]}. A record hits entry k only if entry k is valid, its page equals `rec_page` and its node equals `rec_dst`. When several entries hit, the lowest index is the one passed on.
- R3: An event descriptor is written with `cfg_sel`=1, with top offset in bits [11:0], bottom offset in bits [23:12] and page index in bits [26:24]. An event matches only if its page index equals the index that hit and bottom <= offset <= top, both bounds inclusive. A descriptor with bottom > top never matches.
- R4: The descriptor's command field in bits [28:27] must equal `rec_cmd`, where read=0, write=1, lock=2 and unlock=3. Direction (bit 29) must equal `rec_dir` unless bit 30 is set. The request/response value (bit 31) must equal `rec_kind` unless bit 32 is set. The source node (bits [38:33]) must equal `rec_src` unless bit 39 is set.
- R5: A write with `cfg_sel`=2 sets the arm state of event `cfg_idx` to `cfg_data[0]`. A matching record advances the counter only while that event is armed.
- R6: When one accepted record matches several armed events, each of those counters advances by exactly one.
- R7: Writing an event descriptor clears that event's counter to 0 and leaves its arm state as it was. The clear wins over an increment in the same cycle.
- R8: A configuration write takes effect from the cycle after it. A record accepted in the same cycle as the write is classified with the old settings.
- R9: An increment that would make a counter all ones (0xFFFF) instead clears the counter to 0. The event is then queued for spill, and the spill is presented from the next cycle with `spill_count` = 0xFFFF. A counter never reads all ones.
- R10: Queued spills are presented lowest event index first. While `spill_ready` is low, `spill_valid` stays high and `spill_idx` does not change.
- R11: `rec_ready` is low in every cycle in which a spill is queued.
- R12: A record that misses the page table, or matches no armed event, is accepted and changes no counter.
- R13: `rd_count` shows, in the same cycle, the counter of the event selected by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Record accepted this cycle when high with rec_valid |
| rec_cmd | input | 2 | Command: read=0, write=1, lock=2, unlock=3 |
| rec_src | input | 6 | Source node |
| rec_dst | input | 6 | Destination node |
| rec_page | input | 20 | Page number |
| rec_ofs | input | 12 | Offset within page |
| rec_dir | input | 1 | Direction flag |
| rec_kind | input | 1 | Request/response flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 page entry, 1 event descriptor, 2 arm state, 3 none |
| cfg_idx | input | 3 | Entry index |
| cfg_data | input | 40 | Write data |
| rd_idx | input | 3 | Counter select |
| rd_count | output | 16 | Selected counter value |
| spill_valid | output | 1 | Spill word present |
| spill_ready | input | 1 | Spill consumer accepts |
| spill_idx | output | 3 | Index of the event that overflowed |
| spill_count | output | 16 | Spilled count, always all ones |

## Verification
Two things can land on the same clock edge: a software change to an event's arm state, and a record that matches that event. The bench drives an arm write and a matching record in the same cycle. It expects the record to be judged by the old disarmed state, and then expects the next record to count. It repeats this with a disarm write, where the record in that cycle must still count. A second collision comes from two events that overflow on the same record. Both must be spilled in index order while the consumer stalls and the record input stays held off.

// File: rtl/pfec_pkg.sv
package pfec_pkg;
  parameter int PAGE_W   = 20;
  parameter int OFS_W    = 12;
  parameter int NODE_W   = 6;
  parameter int CNT_W    = 16;
  parameter int N_PAGES  = 8;
  parameter int N_EVENTS = 8;

  localparam int CMD_W     = 2;
  localparam int PIDX_W    = $clog2(N_PAGES);
  localparam int EIDX_W    = $clog2(N_EVENTS);
  localparam int CFG_IDX_W = (PIDX_W > EIDX_W) ? PIDX_W : EIDX_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_LOCK   = 2'd2,
    CMD_UNLOCK = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    CFG_PAGE  = 2'd0,
    CFG_EVENT = 2'd1,
    CFG_ARM   = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              vld;
    logic [NODE_W-1:0] node;
    logic [PAGE_W-1:0] page;
  } page_ent_t;

  typedef struct packed {
    logic              src_any;
    logic [NODE_W-1:0] src;
    logic              kind_any;
    logic              kind;
    logic              dir_any;
    logic              dir;
    logic [CMD_W-1:0]  cmd;
    logic [PIDX_W-1:0] pidx;
    logic [OFS_W-1:0]  bot;
    logic [OFS_W-1:0]  top;
  } ev_desc_t;

  localparam int PAGE_ENT_W = $bits(page_ent_t);
  localparam int EV_DESC_W  = $bits(ev_desc_t);
  localparam int CFG_W      = (PAGE_ENT_W > EV_DESC_W) ? PAGE_ENT_W : EV_DESC_W;

  // Inclusive window; an empty window (bot > top) admits nothing.
  function automatic logic ofs_in_window(input logic [OFS_W-1:0] o,
                                         input logic [OFS_W-1:0] b,
                                         input logic [OFS_W-1:0] t);
    return (o >= b) && (o <= t);
  endfunction

  function automatic logic type_ok(input ev_desc_t d,
                                   input logic [CMD_W-1:0] cmd,
                                   input logic [NODE_W-1:0] src,
                                   input logic dir,
                                   input logic kind);
    return (d.cmd == cmd) &&
           (d.dir_any  || (d.dir  == dir)) &&
           (d.kind_any || (d.kind == kind)) &&
           (d.src_any  || (d.src  == src));
  endfunction

  // Returns {wrapped, next}; reaching all ones wraps to zero.
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] n;
    n = c + 1'b1;
    if (n == {CNT_W{1'b1}}) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, n};
  endfunction

  function automatic logic [EIDX_W-1:0] lowest_set(input logic [N_EVENTS-1:0] v);
    logic [EIDX_W-1:0] r;
    r = '0;
    for (int i = N_EVENTS - 1; i >= 0; i--) begin
      if (v[i]) r = EIDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pfec_page_table.sv
module pfec_page_table
  import pfec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  page_ent_t         wr_ent,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic [NODE_W-1:0] lk_node,
  output logic              hit,
  output logic [PIDX_W-1:0] hit_idx
);
  logic [N_PAGES-1:0] eq;

  generate
    for (genvar g = 0; g < N_PAGES; g++) begin : g_ent
      page_ent_t ent;
      always_ff @(posedge clk) begin
        if (!rst_n)                                ent <= '0;
        else if (wr_en && wr_idx == PIDX_W'(g))    ent <= wr_ent;
      end
      assign eq[g] = ent.vld && (ent.page == lk_page) && (ent.node == lk_node);
    end
  endgenerate

  // Lowest matching slot wins.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_PAGES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = PIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pfec_event_station.sv
module pfec_event_station
  import pfec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_we,
  input  logic                arm_we,
  input  logic [EIDX_W-1:0]   wr_idx,
  input  ev_desc_t            wr_desc,
  input  logic                arm_val,
  input  logic                pg_hit,
  input  logic [PIDX_W-1:0]   pg_idx,
  input  logic [CMD_W-1:0]    r_cmd,
  input  logic [NODE_W-1:0]   r_src,
  input  logic [OFS_W-1:0]    r_ofs,
  input  logic                r_dir,
  input  logic                r_kind,
  output logic [N_EVENTS-1:0] fire,
  output logic [N_EVENTS-1:0] armed
);
  generate
    for (genvar g = 0; g < N_EVENTS; g++) begin : g_ev
      ev_desc_t desc;
      logic     en;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          desc <= '0;
          en   <= 1'b0;
        end else begin
          if (desc_we && wr_idx == EIDX_W'(g)) desc <= wr_desc;
          if (arm_we  && wr_idx == EIDX_W'(g)) en   <= arm_val;
        end
      end
      assign fire[g]  = pg_hit && (desc.pidx == pg_idx) &&
                        ofs_in_window(r_ofs, desc.bot, desc.top) &&
                        type_ok(desc, r_cmd, r_src, r_dir, r_kind);
      assign armed[g] = en;
    end
  endgenerate
endmodule

// File: rtl/pfec_counter_bank.sv
module pfec_counter_bank
  import pfec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVENTS-1:0] clr,
  input  logic [N_EVENTS-1:0] inc,
  input  logic [EIDX_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]    rd_count,
  output logic [N_EVENTS-1:0] ovf,
  output logic                spill_valid,
  input  logic                spill_ready,
  output logic [EIDX_W-1:0]   spill_idx,
  output logic [CNT_W-1:0]    spill_count
);
  logic [CNT_W-1:0]    cnt [N_EVENTS];
  logic [N_EVENTS-1:0] pend;
  logic [N_EVENTS-1:0] take;

  generate
    for (genvar g = 0; g < N_EVENTS; g++) begin : g_cnt
      logic [CNT_W:0]   nx;
      logic [CNT_W-1:0] c;
      assign nx     = bump(c);
      assign ovf[g] = inc[g] && !clr[g] && nx[CNT_W];
      always_ff @(posedge clk) begin
        if (!rst_n)      c <= '0;
        else if (clr[g]) c <= '0;
        else if (inc[g]) c <= nx[CNT_W-1:0];
      end
      assign cnt[g] = c;
    end
  endgenerate

  assign rd_count    = cnt[rd_idx];
  assign spill_valid = |pend;
  assign spill_idx   = lowest_set(pend);
  assign spill_count = {CNT_W{1'b1}};

  always_comb begin
    take = '0;
    if (spill_valid && spill_ready) take[spill_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~take) | ovf;
  end
endmodule

// File: rtl/pfec_unit.sv
module pfec_unit
  import pfec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rec_valid,
  output logic                 rec_ready,
  input  logic [CMD_W-1:0]     rec_cmd,
  input  logic [NODE_W-1:0]    rec_src,
  input  logic [NODE_W-1:0]    rec_dst,
  input  logic [PAGE_W-1:0]    rec_page,
  input  logic [OFS_W-1:0]     rec_ofs,
  input  logic                 rec_dir,
  input  logic                 rec_kind,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic [EIDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]     rd_count,
  output logic                 spill_valid,
  input  logic                 spill_ready,
  output logic [EIDX_W-1:0]    spill_idx,
  output logic [CNT_W-1:0]     spill_count
);
  logic                cfg_page_we, cfg_desc_we, cfg_arm_we;
  logic                rec_accept;
  logic                pt_hit;
  logic [PIDX_W-1:0]   pt_hit_idx;
  logic [N_EVENTS-1:0] ev_fire, ev_armed, ev_inc, ev_clr, ev_ovf;

  always_comb begin
    cfg_page_we = 1'b0;
    cfg_desc_we = 1'b0;
    cfg_arm_we  = 1'b0;
    if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_PAGE:  cfg_page_we = 1'b1;
        CFG_EVENT: cfg_desc_we = 1'b1;
        CFG_ARM:   cfg_arm_we  = 1'b1;
        default:   ;
      endcase
    end
  end

  pfec_page_table u_pt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_page_we),
    .wr_idx  (cfg_idx[PIDX_W-1:0]),
    .wr_ent  (page_ent_t'(cfg_data[PAGE_ENT_W-1:0])),
    .lk_page (rec_page),
    .lk_node (rec_dst),
    .hit     (pt_hit),
    .hit_idx (pt_hit_idx)
  );

  pfec_event_station u_es (
    .clk     (clk),
    .rst_n   (rst_n),
    .desc_we (cfg_desc_we),
    .arm_we  (cfg_arm_we),
    .wr_idx  (cfg_idx[EIDX_W-1:0]),
    .wr_desc (ev_desc_t'(cfg_data[EV_DESC_W-1:0])),
    .arm_val (cfg_data[0]),
    .pg_hit  (pt_hit),
    .pg_idx  (pt_hit_idx),
    .r_cmd   (rec_cmd),
    .r_src   (rec_src),
    .r_ofs   (rec_ofs),
    .r_dir   (rec_dir),
    .r_kind  (rec_kind),
    .fire    (ev_fire),
    .armed   (ev_armed)
  );

  assign rec_ready  = !spill_valid;
  assign rec_accept = rec_valid && rec_ready;
  assign ev_inc     = ev_fire & ev_armed & {N_EVENTS{rec_accept}};

  always_comb begin
    ev_clr = '0;
    if (cfg_desc_we) ev_clr[cfg_idx[EIDX_W-1:0]] = 1'b1;
  end

  pfec_counter_bank u_cb (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (ev_clr),
    .inc         (ev_inc),
    .rd_idx      (rd_idx),
    .rd_count    (rd_count),
    .ovf         (ev_ovf),
    .spill_valid (spill_valid),
    .spill_ready (spill_ready),
    .spill_idx   (spill_idx),
    .spill_count (spill_count)
  );
endmodule

// File: rtl/pfec_checker.sv
module pfec_checker
  import pfec_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rec_valid,
  input logic                rec_ready,
  input logic                spill_valid,
  input logic                spill_ready,
  input logic [EIDX_W-1:0]   spill_idx,
  input logic [CNT_W-1:0]    spill_count,
  input logic [CNT_W-1:0]    rd_count,
  input logic                pt_hit,
  input logic [N_EVENTS-1:0] ev_inc,
  input logic [N_EVENTS-1:0] ev_ovf
);
  p_stall_on_spill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> !rec_ready);

  p_spill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid && !spill_ready |=> spill_valid && $stable(spill_idx));

  p_full_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> spill_count == {CNT_W{1'b1}});

  p_ovf_spills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_ovf) |=> spill_valid);

  p_never_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count != {CNT_W{1'b1}});

  p_inc_needs_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_inc) |-> pt_hit);

  p_inc_needs_record_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_inc) |-> rec_valid);
endmodule

bind pfec_unit pfec_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_valid   (rec_valid),
  .rec_ready   (rec_ready),
  .spill_valid (spill_valid),
  .spill_ready (spill_ready),
  .spill_idx   (spill_idx),
  .spill_count (spill_count),
  .rd_count    (rd_count),
  .pt_hit      (pt_hit),
  .ev_inc      (ev_inc),
  .ev_ovf      (ev_ovf)
);

// File: tb/pfec_unit_test.sv
module pfec_unit_test;
  import pfec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [1:0]  rec_cmd = '0;
  logic [5:0]  rec_src = '0;
  logic [5:0]  rec_dst = '0;
  logic [19:0] rec_page = '0;
  logic [11:0] rec_ofs = '0;
  logic        rec_dir = 1'b0;
  logic        rec_kind = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [2:0]  cfg_idx = '0;
  logic [39:0] cfg_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_count;
  logic        spill_valid;
  logic        spill_ready = 1'b1;
  logic [2:0]  spill_idx;
  logic [15:0] spill_count;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pfec_unit uut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_cmd(rec_cmd), .rec_src(rec_src), .rec_dst(rec_dst), .rec_page(rec_page),
    .rec_ofs(rec_ofs), .rec_dir(rec_dir), .rec_kind(rec_kind),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_idx(rd_idx), .rd_count(rd_count), .spill_valid(spill_valid),
    .spill_ready(spill_ready), .spill_idx(spill_idx), .spill_count(spill_count)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] page_word(input bit v, input int node, input int page);
    return {13'd0, v, node[5:0], page[19:0]};
  endfunction

  // any bits: src_any, kind_any, dir_any
  function automatic logic [39:0] ev_word(input int pidx, input int cmd, input int bot, input int top,
                                          input bit dany, input bit d, input bit kany, input bit k,
                                          input bit sany, input int s);
    logic [39:0] w;
    w = '0;
    w[11:0]  = top[11:0];
    w[23:12] = bot[11:0];
    w[26:24] = pidx[2:0];
    w[28:27] = cmd[1:0];
    w[29]    = d;
    w[30]    = dany;
    w[31]    = k;
    w[32]    = kany;
    w[38:33] = s[5:0];
    w[39]    = sany;
    return w;
  endfunction

  task automatic cfg(input int sel, input int idx, input logic [39:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_idx = idx[2:0]; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic set_rec(input int c, input int s, input int d, input int p, input int o,
                         input bit dr, input bit kd);
    rec_cmd = c[1:0]; rec_src = s[5:0]; rec_dst = d[5:0];
    rec_page = p[19:0]; rec_ofs = o[11:0]; rec_dir = dr; rec_kind = kd;
  endtask

  // Offers the same record until n of them are accepted; returns at the negedge after the last.
  task automatic send(input int c, input int s, input int d, input int p, input int o,
                      input bit dr, input bit kd, input int n);
    int acc;
    @(negedge clk);
    set_rec(c, s, d, p, o, dr, kd);
    rec_valid = 1'b1;
    acc = 0;
    while (acc < n) begin
      if (rec_ready) acc++;
      @(negedge clk);
    end
    rec_valid = 1'b0;
  endtask

  task automatic cnt_is(input string req, input int idx, input int exp);
    rd_idx = idx[2:0];
    #1;
    check(req, $sformatf("count of event %0d", idx), int'(rd_count), exp);
  endtask

  task automatic t_reset;
    check("R1", "rec_ready", int'(rec_ready), 1);
    check("R1", "spill_valid", int'(spill_valid), 0);
    for (int i = 0; i < 8; i++) cnt_is("R1 R13", i, 0);
  endtask

  task automatic t_program;
    cfg(0, 0, page_word(1, 3, 'h00100));
    cfg(0, 1, page_word(1, 5, 'h00200));
    cfg(0, 2, page_word(0, 1, 'h00300));
    cfg(0, 3, page_word(1, 5, 'h00200));
    cfg(1, 0, ev_word(0, CMD_WRITE, 'h010, 'h020, 1, 0, 1, 0, 1, 0));
    cfg(1, 1, ev_word(1, CMD_READ,  'h000, 'hFFF, 1, 0, 1, 0, 1, 0));
    cfg(1, 2, ev_word(3, CMD_READ,  'h000, 'hFFF, 1, 0, 1, 0, 1, 0));
    cfg(1, 3, ev_word(0, CMD_WRITE, 'h030, 'h02F, 1, 0, 1, 0, 1, 0));
    cfg(1, 4, ev_word(0, CMD_WRITE, 'h000, 'hFFF, 0, 1, 1, 0, 0, 7));
    cfg(1, 5, ev_word(0, CMD_WRITE, 'h010, 'h020, 1, 0, 1, 0, 1, 0));
    cfg(1, 6, ev_word(2, CMD_READ,  'h000, 'hFFF, 1, 0, 1, 0, 1, 0));
    cfg(1, 7, ev_word(1, CMD_LOCK,  'h100, 'h100, 1, 0, 1, 0, 1, 0));
    for (int i = 0; i < 7; i++) cfg(2, i, 40'd1);
    // R5: a matching record before arming leaves the counter alone
    send(CMD_LOCK, 0, 5, 'h200, 'h100, 0, 0, 1);
    cnt_is("R5", 7, 0);
  endtask

  task automatic t_range;
    send(CMD_WRITE, 0, 3, 'h100, 'h010, 0, 0, 1);
    send(CMD_WRITE, 0, 3, 'h100, 'h020, 0, 0, 1);
    send(CMD_WRITE, 0, 3, 'h100, 'h00F, 0, 0, 1);
    send(CMD_WRITE, 0, 3, 'h100, 'h021, 0, 0, 1);
    send(CMD_WRITE, 0, 3, 'h100, 'h030, 0, 0, 1);
    cnt_is("R3", 0, 2);
    cnt_is("R3 R6", 5, 2);
    cnt_is("R3", 3, 0);
  endtask

  task automatic t_type;
    send(CMD_READ,  0, 3, 'h100, 'h015, 0, 0, 1);
    cnt_is("R4", 0, 2);
    send(CMD_WRITE, 7, 3, 'h100, 'h500, 1, 0, 1);
    send(CMD_WRITE, 6, 3, 'h100, 'h500, 1, 1, 1);
    send(CMD_WRITE, 7, 3, 'h100, 'h500, 0, 1, 1);
    cnt_is("R4", 4, 1);
  endtask

  task automatic t_lookup;
    send(CMD_READ, 0, 5, 'h200, 'h040, 0, 0, 1);
    cnt_is("R2", 1, 1);
    cnt_is("R2", 2, 0);
    send(CMD_READ, 0, 4, 'h200, 'h040, 0, 0, 1);
    send(CMD_READ, 0, 1, 'h300, 'h040, 0, 0, 1);
    check("R12", "rec_ready after misses", int'(rec_ready), 1);
    cnt_is("R12", 1, 1);
    cnt_is("R12", 6, 0);
  endtask

  task automatic t_arm_race;
    // arm write and matching record in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_idx = 3'd7; cfg_data = 40'd1;
    set_rec(CMD_LOCK, 0, 5, 'h200, 'h100, 0, 0);
    rec_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rec_valid = 1'b0;
    cnt_is("R8", 7, 0);
    send(CMD_LOCK, 0, 5, 'h200, 'h100, 0, 0, 1);
    cnt_is("R5", 7, 1);
    // disarm write and matching record in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_idx = 3'd7; cfg_data = 40'd0;
    rec_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rec_valid = 1'b0;
    cnt_is("R8", 7, 2);
    send(CMD_LOCK, 0, 5, 'h200, 'h100, 0, 0, 1);
    cnt_is("R5", 7, 2);
  endtask

  task automatic t_clear;
    cfg(1, 1, ev_word(1, CMD_READ, 'h000, 'hFFF, 1, 0, 1, 0, 1, 0));
    cnt_is("R7", 1, 0);
    send(CMD_READ, 0, 5, 'h200, 'h040, 0, 0, 1);
    cnt_is("R7", 1, 1);
  endtask

  task automatic t_overflow;
    cfg(1, 0, ev_word(0, CMD_WRITE, 'h010, 'h020, 1, 0, 1, 0, 1, 0));
    cfg(1, 5, ev_word(0, CMD_WRITE, 'h010, 'h020, 1, 0, 1, 0, 1, 0));
    cnt_is("R7", 0, 0);
    spill_ready = 1'b0;
    send(CMD_WRITE, 0, 3, 'h100, 'h018, 0, 0, 65534);
    cnt_is("R6", 0, 'hFFFE);
    cnt_is("R6", 5, 'hFFFE);
    check("R9", "spill_valid before wrap", int'(spill_valid), 0);
    send(CMD_WRITE, 0, 3, 'h100, 'h018, 0, 0, 1);
    check("R9", "spill_valid", int'(spill_valid), 1);
    check("R9", "spill_count", int'(spill_count), 'hFFFF);
    check("R10", "first spill_idx", int'(spill_idx), 0);
    check("R11", "rec_ready while queued", int'(rec_ready), 0);
    cnt_is("R9", 0, 0);
    cnt_is("R9", 5, 0);
    repeat (3) @(negedge clk);
    check("R10", "held spill_valid", int'(spill_valid), 1);
    check("R10", "held spill_idx", int'(spill_idx), 0);
    check("R11", "rec_ready still low", int'(rec_ready), 0);
    spill_ready = 1'b1;
    @(negedge clk);
    check("R10", "second spill_idx", int'(spill_idx), 5);
    check("R10", "second spill_valid", int'(spill_valid), 1);
    @(negedge clk);
    check("R10", "drained spill_valid", int'(spill_valid), 0);
    check("R11", "rec_ready after drain", int'(rec_ready), 1);
    send(CMD_WRITE, 0, 3, 'h100, 'h018, 0, 0, 1);
    cnt_is("R9", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_range();
    t_type();
    t_lookup();
    t_arm_race();
    t_clear();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule